// File: doc/BRIEF.md
# Serial EEPROM Sequential Word Reader

This block is a host-side master for a three-wire serial EEPROM with a separate data-in line. It reads a run of consecutive 16-bit words. The user gives a start address and a word count, then pulses `go` for one cycle. The block then drives the select, serial clock and data-out lines, and shifts the data-in line into a 16-bit word.

Each word read is a complete, separate command frame. The frame opens with a select period and then sends the read command and the word address. It then runs seventeen capture clocks. The first captured bit is a zero that the memory places ahead of its data, and the block drops it. Select is released between frames, and one extra clock pulse is given while deselected. A cycle divider sets the length of the serial clock's low and high phases, so the slow memory's minimum pulse widths can be met from a fast system clock.

Each finished word appears on `wordData` and `wordAddr` with a one-cycle `wordValid` strobe. A one-cycle `done` pulse follows the last word.

Top module: `mwr_reader`

## Requirements
- R1: After reset, `eeCs`, `eeSclk`, `eeSdo`, `busy`, `wordValid` and `done` are all low.
- R2: Each frame starts with `eeCs` rising while `eeSclk` is low. It then has one serial clock with `eeSdo` at 0, three clocks carrying 1, 1, 0 (start bit, then read opcode 10), and `ADDR_W` clocks carrying the word address MSB first.
- R3: After the address, exactly 17 serial clocks run with select high. On each of these clocks, `eeSdi` is shifted into a 16-bit register MSB first, so the first captured bit (the leading zero) is dropped. A frame therefore holds 21+`ADDR_W` rising clocks.
- R4: Between frames, and after the last frame, `eeCs` goes low and exactly one serial clock pulse is issued while deselected.
- R5: The frames address `startAddr`, `startAddr`+1, … up to `startAddr`+`wordCount`−1, wrapping modulo 2^`ADDR_W`.
- R6: Every low phase of `eeSclk` within a frame lasts `LOW_CYC` system clocks, and every high phase lasts `HIGH_CYC` system clocks. The defaults are 63 and 188 cycles, which give at least 250 ns low and 750 ns high at 4 ns.
- R7: `eeSdo` changes only on the edge that drives `eeSclk` low. `eeSdi` is sampled on the edge that drives `eeSclk` high.
- R8: `wordValid` is a one-cycle pulse carrying the word and its address. With go sampled at edge E, F = 22+`ADDR_W` and P = `LOW_CYC`+`HIGH_CYC`, word w (counted from 0) is valid after edge E + w·F·P + (F−1)·P.
- R9: `done` is a one-cycle pulse after edge E + `wordCount`·F·P. With `wordCount` = 0, it follows edge E directly and no frame is sent.
- R10: A `go` arriving while `busy` is high is ignored. The running job's addresses, count and timing are unchanged.
- R11: `busy` is high from the cycle after an accepted go with a nonzero count until `done` rises, and `eeCs` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start pulse, accepted only while idle |
| startAddr | input | ADDR_W | First word address |
| wordCount | input | CNT_W | Number of words to read |
| busy | output | 1 | Job in progress |
| wordValid | output | 1 | One-cycle strobe for a finished word |
| wordData | output | 16 | Word read from the memory |
| wordAddr | output | ADDR_W | Address of the word on wordData |
| done | output | 1 | One-cycle pulse after the final word |
| eeCs | output | 1 | Memory select |
| eeSclk | output | 1 | Serial clock |
| eeSdo | output | 1 | Serial command/address to the memory |
| eeSdi | input | 1 | Serial data from the memory |

## Verification
Every result is due at a fixed cycle, counted from the edge that samples `go`. Word w is due w·F·P + (F−1)·P cycles after that edge, and done is due `wordCount`·F·P cycles after it. The bench records a cycle counter at the go edge and samples every output on the falling clock, so each observed strobe is compared with the exact edge count from R8 and R9. The memory model in the bench reacts to each rising `eeSclk` one half cycle after the edge. Its new data bit therefore settles long before the next capture edge, and its checks of the received frame run when select falls.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  localparam int DATA_W = 16;
  localparam int CMD_W = 3;
  localparam logic [CMD_W-1:0] READ_CMD = 3'b110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_SHIFT,
    ST_DATA,
    ST_GAP
  } mwrState_t;

  typedef struct packed {
    logic run;
    logic loadJob;
    logic loadTx;
    logic shiftTx;
    logic capture;
    logic wordDone;
  } mwrStrobe_t;

endpackage

// File: rtl/mwr_dpath.sv
module mwr_dpath
  import mwr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W = 8,
  parameter int LOW_CYC = 63,
  parameter int HIGH_CYC = 188
) (
  input  logic              clk,
  input  logic              rstN,
  input  mwrStrobe_t        strb,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  input  logic              eeSdi,
  output logic              rise,
  output logic              fall,
  output logic              remZero,
  output logic              sclk,
  output logic              sdo,
  output logic              wordValid,
  output logic [DATA_W-1:0] wordData,
  output logic [ADDR_W-1:0] wordAddr
);

  localparam int DIV_MAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int DIV_W = $clog2(DIV_MAX + 1);
  localparam int TX_W = CMD_W + ADDR_W;

  logic [DIV_W-1:0]  divCnt;
  logic [TX_W-1:0]   txShift;
  logic [DATA_W-1:0] rxShift;
  logic [ADDR_W-1:0] curAddr;
  logic [CNT_W-1:0]  remain;

  // phase timer: low phase then high phase per serial bit slot
  assign rise = strb.run && !sclk && (divCnt == DIV_W'(LOW_CYC - 1));
  assign fall = strb.run && sclk && (divCnt == DIV_W'(HIGH_CYC - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      sclk <= 1'b0;
    end else if (!strb.run) begin
      divCnt <= '0;
      sclk <= 1'b0;
    end else if (rise) begin
      divCnt <= '0;
      sclk <= 1'b1;
    end else if (fall) begin
      divCnt <= '0;
      sclk <= 1'b0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // command/address shifter; empties to zero after its last bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
    end else if (strb.loadTx) begin
      txShift <= {READ_CMD, curAddr};
    end else if (strb.shiftTx) begin
      txShift <= txShift << 1;
    end
  end
  assign sdo = txShift[TX_W-1];

  // capture shifter; the leading zero falls off the top
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strb.capture) begin
      rxShift <= {rxShift[DATA_W-2:0], eeSdi};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curAddr <= '0;
      remain <= '0;
      wordValid <= 1'b0;
      wordData <= '0;
      wordAddr <= '0;
    end else begin
      wordValid <= 1'b0;
      if (strb.loadJob) begin
        curAddr <= startAddr;
        remain <= wordCount;
      end else if (strb.wordDone) begin
        curAddr <= curAddr + 1'b1;
        remain <= remain - 1'b1;
        wordValid <= 1'b1;
        wordData <= rxShift;
        wordAddr <= curAddr;
      end
    end
  end
  assign remZero = (remain == '0);

endmodule

// File: rtl/mwr_ctrl.sv
module mwr_ctrl
  import mwr_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       go,
  input  logic       goZero,
  input  logic       rise,
  input  logic       fall,
  input  logic       remZero,
  output mwrStrobe_t strb,
  output logic       cs,
  output logic       busy,
  output logic       done
);

  localparam int TX_W = CMD_W + ADDR_W;
  localparam int CAP_CLKS = DATA_W + 1;
  localparam int MAX_BITS = (TX_W > CAP_CLKS) ? TX_W : CAP_CLKS;
  localparam int BIT_W = $clog2(MAX_BITS);

  mwrState_t state;
  logic [BIT_W-1:0] bitCnt;
  logic lastTx;
  logic lastCap;

  assign lastTx = (bitCnt == BIT_W'(TX_W - 1));
  assign lastCap = (bitCnt == BIT_W'(CAP_CLKS - 1));

  always_comb begin
    strb.run = (state != ST_IDLE);
    strb.loadJob = (state == ST_IDLE) && go;
    strb.loadTx = (state == ST_SEL) && fall;
    strb.shiftTx = (state == ST_SHIFT) && fall;
    strb.capture = (state == ST_DATA) && rise;
    strb.wordDone = (state == ST_DATA) && fall && lastCap;
  end
  assign busy = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      bitCnt <= '0;
      cs <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (go) begin
          if (goZero) begin
            done <= 1'b1;
          end else begin
            state <= ST_SEL;
            cs <= 1'b1;
          end
        end
        ST_SEL: if (fall) begin
          state <= ST_SHIFT;
          bitCnt <= '0;
        end
        ST_SHIFT: if (fall) begin
          if (lastTx) begin
            state <= ST_DATA;
            bitCnt <= '0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_DATA: if (fall) begin
          if (lastCap) begin
            state <= ST_GAP;
            cs <= 1'b0;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
        ST_GAP: if (fall) begin
          if (remZero) begin
            state <= ST_IDLE;
            done <= 1'b1;
          end else begin
            state <= ST_SEL;
            cs <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/mwr_reader.sv
module mwr_reader
  import mwr_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int CNT_W = 8,
  parameter int LOW_CYC = 63,
  parameter int HIGH_CYC = 188
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              go,
  input  logic [ADDR_W-1:0] startAddr,
  input  logic [CNT_W-1:0]  wordCount,
  output logic              busy,
  output logic              wordValid,
  output logic [15:0]       wordData,
  output logic [ADDR_W-1:0] wordAddr,
  output logic              done,
  output logic              eeCs,
  output logic              eeSclk,
  output logic              eeSdo,
  input  logic              eeSdi
);

  mwrStrobe_t strb;
  logic rise;
  logic fall;
  logic remZero;
  logic goZero;

  assign goZero = (wordCount == '0);

  mwr_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .go(go), .goZero(goZero),
    .rise(rise), .fall(fall), .remZero(remZero),
    .strb(strb), .cs(eeCs), .busy(busy), .done(done)
  );

  mwr_dpath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb),
    .startAddr(startAddr), .wordCount(wordCount), .eeSdi(eeSdi),
    .rise(rise), .fall(fall), .remZero(remZero),
    .sclk(eeSclk), .sdo(eeSdo),
    .wordValid(wordValid), .wordData(wordData), .wordAddr(wordAddr)
  );

endmodule

// File: rtl/mwr_reader_chk.sv
module mwr_reader_chk #(
  parameter int LOW_CYC = 63,
  parameter int HIGH_CYC = 188
) (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic eeCs,
  input logic eeSclk,
  input logic eeSdo,
  input logic wordValid,
  input logic done
);

  int unsigned hiRun;
  int unsigned loRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRun <= 0;
      loRun <= 0;
    end else if (eeSclk) begin
      loRun <= 0;
      if (hiRun < HIGH_CYC) hiRun <= hiRun + 1;
    end else begin
      hiRun <= 0;
      if (loRun < LOW_CYC) loRun <= loRun + 1;
    end
  end

  assert_high_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(eeSclk) |-> hiRun >= HIGH_CYC);
  assert_low_width_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeSclk) |-> loRun >= LOW_CYC);
  assert_sdo_moves_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(eeSdo) |-> !eeSclk);
  assert_select_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> (!eeSclk && !eeSdo));
  assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);
  assert_valid_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> busy);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  assert_cs_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    eeCs |-> busy);

endmodule

bind mwr_reader mwr_reader_chk #(.LOW_CYC(LOW_CYC), .HIGH_CYC(HIGH_CYC)) u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .eeCs(eeCs), .eeSclk(eeSclk),
  .eeSdo(eeSdo), .wordValid(wordValid), .done(done)
);

// File: tb/mwr_reader_bench.sv
`timescale 1ns/1ps
module mwr_reader_bench;

  localparam int BA = 6;
  localparam int BC = 8;
  localparam int LOWC = 3;
  localparam int HIGHC = 5;
  localparam int P = LOWC + HIGHC;
  localparam int F = 22 + BA;
  localparam int AMASK = (1 << BA) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic go = 1'b0;
  logic [BA-1:0] startAddr = '0;
  logic [BC-1:0] wordCount = '0;
  logic busy, wordValid, done, eeCs, eeSclk, eeSdo;
  logic eeSdi = 1'b1;
  logic [15:0] wordData;
  logic [BA-1:0] wordAddr;

  int checks = 0;
  int fails = 0;
  longint cyc = 0;
  longint goCyc = 0;
  int jobStart = 0;
  int wIdx = 0;
  int frameIdx = 0;
  int gapRises = 0;
  bit finished = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  mwr_reader #(.ADDR_W(BA), .CNT_W(BC), .LOW_CYC(LOWC), .HIGH_CYC(HIGHC)) u_mwr_reader (
    .clk(clk), .rstN(rstN), .go(go), .startAddr(startAddr), .wordCount(wordCount),
    .busy(busy), .wordValid(wordValid), .wordData(wordData), .wordAddr(wordAddr),
    .done(done), .eeCs(eeCs), .eeSclk(eeSclk), .eeSdo(eeSdo), .eeSdi(eeSdi)
  );

  function automatic logic [15:0] memFn(input int a);
    int v;
    v = a * 40503 + 12345;
    return v[15:0] ^ {v[3:0], 12'h000};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model, evaluated half a cycle away from the design's edges
  logic prevSclk = 1'b0;
  logic prevCs = 1'b0;
  int riseNo = 0;
  int hiLen = 0;
  int loLen = 0;
  logic selBit;
  logic [2:0] cmdBits;
  logic [BA-1:0] rxAddr;
  logic [15:0] memWord;

  always @(negedge clk) begin
    if (eeCs && !prevCs) begin
      riseNo = 0;
      cmdBits = '0;
      rxAddr = '0;
      selBit = 1'b0;
      if (frameIdx > 0) chk(gapRises == 1, "R4 deselect pulses", gapRises, 1);
      gapRises = 0;
    end
    if (eeSclk && !prevSclk) begin
      if (eeCs) begin
        riseNo++;
        if (riseNo > 1) chk(loLen == LOWC, "R6 low phase", loLen, LOWC);
        if (riseNo == 1) selBit = eeSdo;
        else if (riseNo <= 4) cmdBits = {cmdBits[1:0], eeSdo};
        else if (riseNo <= 4 + BA) rxAddr = {rxAddr[BA-2:0], eeSdo};
        if (riseNo == 4 + BA) begin
          memWord = memFn(int'(rxAddr));
          eeSdi = 1'b0;
        end else if (riseNo > 4 + BA && riseNo <= 20 + BA) begin
          eeSdi = memWord[20 + BA - riseNo];
        end else begin
          eeSdi = 1'b1;
        end
      end else begin
        gapRises++;
      end
    end
    if (!eeSclk && prevSclk && eeCs) chk(hiLen == HIGHC, "R6 high phase", hiLen, HIGHC);
    if (!eeCs && prevCs) begin
      chk(riseNo == 21 + BA, "R3 clocks per frame", riseNo, 21 + BA);
      chk(selBit == 1'b0, "R2 select clock data", selBit, 0);
      chk(cmdBits == 3'b110, "R2 command bits", cmdBits, 3'b110);
      chk(int'(rxAddr) == ((jobStart + frameIdx) & AMASK), "R5 frame address",
          rxAddr, (jobStart + frameIdx) & AMASK);
      frameIdx++;
      eeSdi = 1'b1;
    end
    if (eeSclk) begin hiLen++; loLen = 0; end
    else begin loLen++; hiLen = 0; end
    prevSclk = eeSclk;
    prevCs = eeCs;
  end

  // word monitor: R3 data, R5 address, R8 timing
  always @(negedge clk) begin
    if (rstN && wordValid) begin
      int ea;
      ea = (jobStart + wIdx) & AMASK;
      chk(wordData == memFn(ea), "R3 word data", wordData, memFn(ea));
      chk(int'(wordAddr) == ea, "R5 word address", wordAddr, ea);
      chk((cyc - goCyc) == longint'(wIdx * F * P + (F - 1) * P), "R8 word timing",
          cyc - goCyc, wIdx * F * P + (F - 1) * P);
      wIdx++;
    end
  end

  task automatic runJob(input int st, input int n, input bit busyGo);
    int lat;
    jobStart = st;
    wIdx = 0;
    frameIdx = 0;
    gapRises = 0;
    startAddr = BA'(st);
    wordCount = BC'(n);
    go = 1'b1;
    @(posedge clk);
    @(negedge clk);
    go = 1'b0;
    goCyc = cyc;
    if (n > 0) chk(busy == 1'b1, "R11 busy after go", busy, 1);
    lat = 0;
    while (!done && lat < 20000) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      go = busyGo && (lat == 100);
      if (go) begin
        startAddr = BA'(st ^ 21);
        wordCount = BC'(2);
      end
    end
    go = 1'b0;
    chk(lat == n * F * P, "R9 done latency", lat, n * F * P);
    chk(wIdx == n, "R8 words delivered", wIdx, n);
    chk(busy == 1'b0, "R11 idle at done", busy, 0);
    if (n > 0) chk(gapRises == 1, "R4 final deselect pulse", gapRises, 1);
    if (busyGo) chk(frameIdx == n, "R10 busy go ignored", frameIdx, n);
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R9 done one cycle", done, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    int seedVal;
    seedVal = int'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk({eeCs, eeSclk, eeSdo, busy, wordValid, done} == 6'b0, "R1 reset state",
        {eeCs, eeSclk, eeSdo, busy, wordValid, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk({eeCs, eeSclk, eeSdo, busy} == 4'b0, "R1 idle after reset",
        {eeCs, eeSclk, eeSdo, busy}, 0);
    runJob(0, 1, 1'b0);
    runJob(62, 4, 1'b0);
    runJob(17, 0, 1'b0);
    chk(wIdx == 0 && frameIdx == 0, "R9 empty job sends nothing", frameIdx, 0);
    runJob(33, 3, 1'b1);
    runJob(63, 1, 1'b0);
    for (int j = 0; j < 6; j++) begin
      runJob(int'($urandom % 64), 1 + int'($urandom % 5), 1'b0);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL R9 watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule